// File: doc/BRIEF.md
# Teletext Page-Memory Host Access Controller

This block is the host-facing side of a teletext-style decoder. It holds eleven write-only control registers, an indirect data port into the character memory and a read-only status byte. The host reaches them over a simple byte bus that takes the place of a two-wire serial slave. A transaction opens with `host_start` and a register index on `host_addr`. Every byte after that goes to the next register, and once the pointer reaches the data port it stays there. From that point successive bytes walk through the memory column by column.

The character memory is addressed by a chapter register (index 8, bits 2:0), a row register (index 9) and a column register (index 10). After reset, and again whenever the host sets the clear command bit, a sweep writes the space code into every cell. The exception is chapter 0, row 0, column 7, which gets the white colour attribute. While the sweep runs, the data port stalls the host. The register contents are exported on a flat bus for the rest of the decoder.

Top module: `ttx_host_ctrl`

## Requirements
- R1: While reset is asserted and after it, `ctrl_regs_o` byte i (bits 8i+7:8i) holds register i. All of registers 0 to 10 are 0x00, except registers 5 and 6, which are 0x03.
- R2: When the sweep has finished, every memory byte reads 0x20, except chapter 0, row 0, column 7, which reads 0x07.
- R3: `host_addr` index i (0 to 10) selects register i. Each accepted write at a register index stores the byte there and moves the transaction pointer to index+1.
- R4: A read at any index 0 to 10 returns 0x00 and still advances the pointer.
- R5: Index 11 is the memory data port. A write stores the byte at (register 8 bits 2:0, register 9, register 10). A read returns that byte with `host_rvalid` high one cycle after acceptance.
- R6: Each accepted data-port access advances column register 10 by one. A column of 39 or more wraps to 0 and advances row register 9, and a row of 25 or more wraps to 0.
- R7: With chapter ≥ CHAPTERS, row ≥ 26 or column ≥ 40, a data-port write changes no memory byte and a read returns 0x00. The pointers still advance per R6.
- R8: Writing register 8 with bit 3 set starts a sweep of one cell per clock, and a sweep also runs after reset. During the sweep, status index 12 reads 0x01 and data-port accesses raise `host_stall` and have no effect. Afterwards register 8 bit 3 reads 0 on `ctrl_regs_o` and status reads 0x00.
- R9: A write at status index 12 changes no register and starts nothing. The pointer stays at 12.
- R10: The transaction pointer stays at index 11 after data-port accesses, so further bytes in the same transaction keep going to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_start | input | 1 | Opens a transaction at `host_addr` |
| host_addr | input | 4 | Register index: 0-10 control, 11 data port, 12 status |
| host_wr | input | 1 | Byte write request |
| host_rd | input | 1 | Byte read request (ignored when `host_wr` is high) |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid with `host_rvalid` |
| host_rvalid | output | 1 | Read data valid, one cycle after an accepted read |
| host_stall | output | 1 | Data-port access refused during a sweep; the host retries |
| ctrl_regs_o | output | 88 | Registers 0 to 10, one byte each |

## Verification
A wrong pointer update shows up on `ctrl_regs_o` as a bad row or column byte in the cycle after the access. It then shows up again as a wrong byte on the next data-port read, because the read goes to a neighbouring cell. A sweep that ends early or writes the wrong pattern is only seen when a cell is read back. A sweep that never ends shows as status staying at 0x01 and `host_stall` staying high. The bench therefore reads whole rows and far corners after each sweep. An out-of-range write that aliases onto a real cell is visible only by reading that cell back, so each out-of-range case is followed by a read of the cell it would have hit.

// File: rtl/ttx_host_pkg.sv
package ttx_host_pkg;
  localparam int NUM_REGS = 11;
  localparam int IDX_DISP_A = 5;
  localparam int IDX_DISP_B = 6;
  localparam int IDX_CHAP = 8;
  localparam int IDX_ROW = 9;
  localparam int IDX_COL = 10;
  localparam logic [3:0] IDX_DATA = 4'd11;
  localparam logic [3:0] IDX_STAT = 4'd12;
  localparam int CLR_BIT = 3;
  localparam int CHAP_BITS = 3;
  localparam logic [7:0] DISP_RST = 8'h03;
  localparam logic [7:0] SPACE_CODE = 8'h20;
  localparam logic [7:0] WHITE_CODE = 8'h07;
  localparam int SPECIAL_COL = 7;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_MEM  = 2'd1,
    SRC_STAT = 2'd2
  } rd_src_e;
endpackage

// File: rtl/ttx_char_ram.sv
module ttx_char_ram #(
  parameter int DEPTH = 2080,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ttx_init_seq.sv
module ttx_init_seq
  import ttx_host_pkg::*;
#(
  parameter int DEPTH = 2080,
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy_o,
  output logic          done_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    data_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [AW-1:0] SPECIAL_IDX = AW'(SPECIAL_COL);

  logic [AW-1:0] idx_q, idx_d;
  logic          busy_q, busy_d;
  logic          last;

  assign last = (idx_q == LAST_IDX);

  always_comb begin
    idx_d  = idx_q;
    busy_d = busy_q;
    if (start) begin
      idx_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      idx_d  = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else begin
      idx_q  <= idx_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && last && !start;
  assign we_o   = busy_q;
  assign addr_o = idx_q;
  assign data_o = (idx_q == SPECIAL_IDX) ? WHITE_CODE : SPACE_CODE;

  a_r8_sweep_stays_in_memory: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (idx_q <= LAST_IDX));
endmodule

// File: rtl/ttx_reg_bank.sv
module ttx_reg_bank
  import ttx_host_pkg::*;
#(
  parameter int ROWS = 26,
  parameter int COLS = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [3:0]            wr_idx,
  input  logic [7:0]            wr_data,
  input  logic                  step,
  input  logic                  sweep_done,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  clr_req_o
);
  localparam logic [7:0] COL_LAST = 8'(COLS - 1);
  localparam logic [7:0] ROW_LAST = 8'(ROWS - 1);

  logic [7:0] col_cur, row_cur, col_nxt, row_nxt;
  logic       col_wrap;

  assign col_cur  = regs_o[IDX_COL*8 +: 8];
  assign row_cur  = regs_o[IDX_ROW*8 +: 8];
  assign col_wrap = (col_cur >= COL_LAST);

  always_comb begin
    col_nxt = col_wrap ? 8'd0 : col_cur + 8'd1;
    row_nxt = row_cur;
    if (col_wrap) row_nxt = (row_cur >= ROW_LAST) ? 8'd0 : row_cur + 8'd1;
  end

  assign clr_req_o = wr_en && (wr_idx == 4'(IDX_CHAP)) && wr_data[CLR_BIT];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_VAL = (g == IDX_DISP_A || g == IDX_DISP_B) ? DISP_RST : 8'h00;
    logic [7:0] q, d;
    logic       en;

    always_comb begin
      d  = q;
      en = 1'b0;
      if (g == IDX_CHAP && sweep_done) begin
        d[CLR_BIT] = 1'b0;
        en = 1'b1;
      end
      if (g == IDX_ROW && step) begin
        d  = row_nxt;
        en = 1'b1;
      end
      if (g == IDX_COL && step) begin
        d  = col_nxt;
        en = 1'b1;
      end
      if (wr_en && (wr_idx == 4'(g))) begin
        d  = wr_data;
        en = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST_VAL;
      else if (en) q <= d;
    end

    assign regs_o[g*8 +: 8] = q;
  end

  // R6: column advance and wrap
  a_r6_col_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && col_cur < COL_LAST) |=> (col_cur == $past(col_cur) + 8'd1));
  a_r6_col_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && col_cur >= COL_LAST) |=> (col_cur == 8'd0));
  a_r6_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_en && col_cur >= COL_LAST && row_cur >= ROW_LAST) |=> (row_cur == 8'd0));
endmodule

// File: rtl/ttx_host_ctrl.sv
module ttx_host_ctrl
  import ttx_host_pkg::*;
#(
  parameter int CHAPTERS = 2,
  parameter int ROWS = 26,
  parameter int COLS = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_start,
  input  logic [3:0]            host_addr,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  output logic                  host_rvalid,
  output logic                  host_stall,
  output logic [NUM_REGS*8-1:0] ctrl_regs_o
);
  localparam int DEPTH = CHAPTERS * ROWS * COLS;
  localparam int AW = $clog2(DEPTH);
  localparam logic [7:0] CH_LIM = 8'(CHAPTERS);
  localparam logic [7:0] ROW_LIM = 8'(ROWS);
  localparam logic [7:0] COL_LIM = 8'(COLS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  // transaction pointer and access decode
  logic [3:0] ptr_q, ptr_d, eff_idx;
  logic       ptr_en;
  logic       wr_acc, rd_acc, any_acc, acc_ok;
  logic       is_data, is_stat, is_reg;
  logic       step, reg_wr, busy;

  assign eff_idx = host_start ? host_addr : ptr_q;
  assign wr_acc  = host_wr;
  assign rd_acc  = host_rd && !host_wr;
  assign any_acc = wr_acc || rd_acc;
  assign is_data = (eff_idx == IDX_DATA);
  assign is_stat = (eff_idx == IDX_STAT);
  assign is_reg  = (eff_idx < 4'(NUM_REGS));

  assign host_stall = busy && any_acc && is_data;
  assign acc_ok     = any_acc && !host_stall;
  assign step       = acc_ok && is_data;
  assign reg_wr     = wr_acc && is_reg;

  always_comb begin
    ptr_d  = eff_idx;
    ptr_en = host_start || acc_ok;
    if (acc_ok && is_reg) ptr_d = eff_idx + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= 4'd0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  // registers
  logic sweep_done, clr_req;
  ttx_reg_bank #(.ROWS(ROWS), .COLS(COLS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_ni),
    .wr_en      (reg_wr),
    .wr_idx     (eff_idx),
    .wr_data    (host_wdata),
    .step       (step),
    .sweep_done (sweep_done),
    .regs_o     (ctrl_regs_o),
    .clr_req_o  (clr_req)
  );

  // init sweep
  logic          sweep_we;
  logic [AW-1:0] sweep_addr;
  logic [7:0]    sweep_data;
  ttx_init_seq #(.DEPTH(DEPTH), .AW(AW)) u_init (
    .clk    (clk),
    .rst_n  (rst_ni),
    .start  (clr_req),
    .busy_o (busy),
    .done_o (sweep_done),
    .we_o   (sweep_we),
    .addr_o (sweep_addr),
    .data_o (sweep_data)
  );

  // pointer to memory address
  logic [7:0]    chap, row, col;
  logic          in_range;
  logic [AW-1:0] lin;
  assign chap     = {{(8-CHAP_BITS){1'b0}}, ctrl_regs_o[IDX_CHAP*8 +: CHAP_BITS]};
  assign row      = ctrl_regs_o[IDX_ROW*8 +: 8];
  assign col      = ctrl_regs_o[IDX_COL*8 +: 8];
  assign in_range = (chap < CH_LIM) && (row < ROW_LIM) && (col < COL_LIM);
  assign lin      = AW'((32'(chap) * 32'(ROWS) + 32'(row)) * 32'(COLS) + 32'(col));

  logic          host_mem_we, mem_re, ram_we;
  logic [AW-1:0] ram_waddr;
  logic [7:0]    ram_wdata, ram_q;
  assign host_mem_we = step && wr_acc && in_range;
  assign mem_re      = step && rd_acc && in_range;
  assign ram_we      = sweep_we || host_mem_we;
  assign ram_waddr   = sweep_we ? sweep_addr : lin;
  assign ram_wdata   = sweep_we ? sweep_data : host_wdata;

  ttx_char_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (mem_re),
    .raddr (lin),
    .rdata (ram_q)
  );

  // read return path
  rd_src_e src_d, src_q;
  logic    rvalid_q, stat_q;

  always_comb begin
    src_d = SRC_ZERO;
    if (is_data && in_range) src_d = SRC_MEM;
    else if (is_stat)        src_d = SRC_STAT;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      src_q    <= SRC_ZERO;
      stat_q   <= 1'b0;
    end else begin
      rvalid_q <= acc_ok && rd_acc;
      if (acc_ok && rd_acc) begin
        src_q  <= src_d;
        stat_q <= busy;
      end
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (rvalid_q) begin
      case (src_q)
        SRC_MEM:  host_rdata = ram_q;
        SRC_STAT: host_rdata = {7'b0, stat_q};
        default:  host_rdata = 8'h00;
      endcase
    end
  end
  assign host_rvalid = rvalid_q;

  // R8: host never writes memory while the sweep owns it
  a_r8_no_write_collision: assert property (@(posedge clk) disable iff (!rst_ni)
    !(sweep_we && host_mem_we));
  // R10: pointer sticks at the data port
  a_r10_ptr_sticks: assert property (@(posedge clk) disable iff (!rst_ni)
    step |=> (ptr_q == IDX_DATA));
  // R9: status write leaves registers untouched
  a_r9_stat_write_noop: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_acc && is_stat && !busy) |=> $stable(ctrl_regs_o));
endmodule

// File: tb/sim_ttx_host_ctrl.sv
module sim_ttx_host_ctrl;
  localparam int CHAPTERS = 2;
  localparam int ROWS = 26;
  localparam int COLS = 40;
  localparam int DEPTH = CHAPTERS * ROWS * COLS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_start = 1'b0;
  logic [3:0]  host_addr = 4'd0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        host_stall;
  logic [87:0] ctrl_regs_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  ttx_host_ctrl #(.CHAPTERS(CHAPTERS), .ROWS(ROWS), .COLS(COLS)) u0 (
    .clk(clk), .rst_n(rst_n), .host_start(host_start), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_stall(host_stall),
    .ctrl_regs_o(ctrl_regs_o)
  );

  function automatic logic [7:0] reg_byte(input int i);
    return ctrl_regs_o[i*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected read data", host_rdata, 8'h00);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata == e, t, host_rdata, e);
      end
    end
  end

  task automatic begin_txn(input logic [3:0] a);
    @(negedge clk);
    host_start = 1'b1;
    host_addr  = a;
    @(negedge clk);
    host_start = 1'b0;
  endtask

  task automatic acc(input bit is_wr, input logic [7:0] d);
    @(negedge clk);
    host_wr    = is_wr;
    host_rd    = !is_wr;
    host_wdata = d;
    #1;
    while (host_stall) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    host_wr = 1'b0;
    host_rd = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    acc(1'b1, d);
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    acc(1'b0, 8'h00);
  endtask

  task automatic set_ptr(input logic [7:0] ch, input logic [7:0] r, input logic [7:0] c);
    begin_txn(4'd8);
    wr(ch);
    wr(r);
    wr(c);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not end");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    for (int i = 0; i < 11; i++) begin
      logic [7:0] e;
      e = (i == 5 || i == 6) ? 8'h03 : 8'h00;
      check(reg_byte(i) == e, "R1 reset value", reg_byte(i), e);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 sweep after reset: busy status and stall
    begin_txn(4'd12);
    rd(8'h01, "R8 status busy after reset");
    begin_txn(4'd11);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = 8'hEE;
    #1;
    check(host_stall == 1'b1, "R8 stall during sweep", {7'b0, host_stall}, 8'h01);
    @(negedge clk);
    host_wr = 1'b0;
    repeat (DEPTH + 20) @(negedge clk);
    check(reg_byte(10) == 8'h00, "R8 stalled access left column", reg_byte(10), 8'h00);
    begin_txn(4'd12);
    rd(8'h00, "R8 status idle");

    // R2 init pattern over row 0, R6 wrap into row 1
    set_ptr(8'd0, 8'd0, 8'd0);
    for (int c = 0; c < COLS; c++) rd((c == 7) ? 8'h07 : 8'h20, "R2 init pattern row 0");
    check(reg_byte(9) == 8'd1, "R6 row advance", reg_byte(9), 8'd1);
    check(reg_byte(10) == 8'd0, "R6 column wrap", reg_byte(10), 8'd0);
    set_ptr(8'd1, 8'd25, 8'd39);
    rd(8'h20, "R2 last cell");

    // R3 register writes with auto increment
    begin_txn(4'd0);
    for (int i = 0; i < 8; i++) wr(8'h10 + 8'(i));
    for (int i = 0; i < 8; i++)
      check(reg_byte(i) == 8'h10 + 8'(i), "R3 register write", reg_byte(i), 8'h10 + 8'(i));

    // R4 register reads return zero
    begin_txn(4'd2);
    rd(8'h00, "R4 read reg 2");
    rd(8'h00, "R4 read reg 3");
    rd(8'h00, "R4 read reg 4");

    // R5 data port write/read, R10 pointer stays on data port
    set_ptr(8'd1, 8'd3, 8'd5);
    wr(8'h41);
    wr(8'h42);
    begin_txn(4'd10);
    wr(8'd5);
    rd(8'h41, "R5 read back col 5");
    rd(8'h42, "R10 second data byte col 6");
    check(reg_byte(10) == 8'd7, "R6 column after two reads", reg_byte(10), 8'd7);

    // R6 row 25 to 0 wrap
    set_ptr(8'd0, 8'd25, 8'd38);
    wr(8'h55);
    wr(8'h56);
    wr(8'h57);
    check(reg_byte(9) == 8'd0, "R6 row wrap", reg_byte(9), 8'd0);
    check(reg_byte(10) == 8'd1, "R6 column after wrap", reg_byte(10), 8'd1);
    set_ptr(8'd0, 8'd0, 8'd0);
    rd(8'h57, "R6 wrapped write landed");
    set_ptr(8'd0, 8'd25, 8'd38);
    rd(8'h55, "R5 col 38");
    rd(8'h56, "R5 col 39");
    set_ptr(8'd0, 8'd4, 8'd39);
    wr(8'h60);
    wr(8'h61);
    check(reg_byte(9) == 8'd5, "R6 row increment", reg_byte(9), 8'd5);
    set_ptr(8'd0, 8'd5, 8'd0);
    rd(8'h61, "R6 next row start");

    // R7 out of range pointers
    set_ptr(8'd0, 8'd26, 8'd0);
    wr(8'h99);
    set_ptr(8'd0, 8'd26, 8'd0);
    rd(8'h00, "R7 row out of range reads zero");
    set_ptr(8'd1, 8'd0, 8'd0);
    rd(8'h20, "R7 row overflow no alias");
    set_ptr(8'd0, 8'd0, 8'd40);
    wr(8'h98);
    check(reg_byte(9) == 8'd1, "R7 pointer still advances", reg_byte(9), 8'd1);
    set_ptr(8'd0, 8'd1, 8'd0);
    rd(8'h20, "R7 column overflow no alias");
    set_ptr(8'd2, 8'd0, 8'd0);
    wr(8'h97);
    set_ptr(8'd2, 8'd0, 8'd0);
    rd(8'h00, "R7 chapter out of range reads zero");

    // R9 status write ignored
    begin
      logic [87:0] snap;
      snap = ctrl_regs_o;
      begin_txn(4'd12);
      wr(8'hFF);
      rd(8'h00, "R9 status after write");
      rd(8'h00, "R9 pointer stays on status");
      tests++;
      if (ctrl_regs_o !== snap) begin
        fails++;
        $display("FAIL R9 registers changed: got %h expected %h", ctrl_regs_o, snap);
      end
    end

    // R8 clear command
    begin_txn(4'd8);
    wr(8'h08);
    check(reg_byte(8) == 8'h08, "R8 clear bit set", reg_byte(8), 8'h08);
    begin_txn(4'd12);
    rd(8'h01, "R8 status busy during clear");
    repeat (DEPTH + 20) @(negedge clk);
    check(reg_byte(8) == 8'h00, "R8 clear bit self-clears", reg_byte(8), 8'h00);
    begin_txn(4'd12);
    rd(8'h00, "R8 status idle after clear");
    set_ptr(8'd0, 8'd0, 8'd0);
    for (int c = 0; c < 8; c++) rd((c == 7) ? 8'h07 : 8'h20, "R2 pattern after clear");
    set_ptr(8'd1, 8'd3, 8'd5);
    rd(8'h20, "R8 clear wiped data");

    repeat (5) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: %0d reads missing, expected 0", exp_q.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule